// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block adds signed products into a 64-bit accumulator. The accumulator is held as two 32-bit words, high and low, and the pair `{high, low}` reads as one two's-complement value. Each accumulate step picks one of two product forms. The long form multiplies two full 32-bit signed operands. The word form multiplies only the low 16 bits of each operand, both taken as signed values.

A saturation-enable input sets how the sum is clipped before it is written back. The clipping rule depends on the product form. With saturation on, the long form limits the high word to a 48-bit signed range by forcing its top bits. The word form clips the sum to the signed 32-bit range and reports an overflow by writing 1 into the high word. With saturation off, both forms keep the 64-bit sum, which wraps on overflow.

The surrounding logic can clear the accumulator, load it directly with a value, or start an accumulate step. Each of these acts in one clock. A done pulse marks each accumulate step as it completes.

Top module: `sat_mac_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulator words read 0 and `done_o` is low.
- R2: With `op_word_i`=0 (long form), the 64-bit signed product of `opa_i` and `opb_i` is added to `{acc_hi_o, acc_lo_o}`. With `sat_en_i`=0 the 64-bit sum wraps modulo 2^64.
- R3: With `op_word_i`=1 (word form), only bits 15:0 of each operand are used, each sign-extended. Bits 31:16 of the operands have no effect on the result.
- R4: In the long form with `sat_en_i`=1, a sum whose bit 63 is set gets 0xFFFF0000 ORed into the high word. Any other sum gets its high word ANDed with 0x00007FFF. The low word is always the low half of the sum.
- R5: In the word form with `sat_en_i`=1, a sum below -2^31 writes 0x00000001 to the high word and 0x80000000 to the low word.
- R6: In the word form with `sat_en_i`=1, a sum above 2^31-1 writes 0x00000001 to the high word and 0x7FFFFFFF to the low word. A sum inside the signed 32-bit range is written back unchanged.
- R7: A `start_i` sampled at a rising edge updates the accumulator at that edge, and `done_o` is high for exactly the following cycle. The accumulator holds its value when no command is given.
- R8: `clr_i` zeroes both words at the next edge. It takes priority over `load_i` and `start_i` in the same cycle, and it raises no done.
- R9: `load_i` writes `load_hi_i` and `load_lo_i` into the two words at the next edge. It takes priority over `start_i` and raises no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the accumulator |
| load_i | input | 1 | Direct load of the accumulator |
| load_hi_i | input | 32 | Value for the high word on load |
| load_lo_i | input | 32 | Value for the low word on load |
| start_i | input | 1 | Start one accumulate step |
| op_word_i | input | 1 | 1: word form (16x16), 0: long form (32x32) |
| sat_en_i | input | 1 | Saturation enable |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| acc_hi_o | output | 32 | High accumulator word |
| acc_lo_o | output | 32 | Low accumulator word |
| done_o | output | 1 | One-cycle pulse when an accumulate step has completed |

## Verification
Some properties are checked on every cycle:
- the command priority and the done pulse;
- the hold behaviour when idle;
- the shapes that saturation allows: after a long-form step the top 17 bits of the high word are all zero, or its top 16 bits are all ones; after a word-form step the result is either a sign-extended 32-bit value or one of the two overflow codes.

Other behaviour shows up only in the bench's scenarios, compared against its behavioural model:
- the exact sums;
- the OR-versus-AND choice in the long form;
- that the upper operand bits are ignored in the word form;
- how an overflow code re-saturates on the next accumulate step.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ACC_W  = 2 * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic              done;
    } mac_state_t;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_ACCUM = 2'd3
    } mac_cmd_e;

endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16
) (
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    input  logic                op_word_i,
    output logic [2*DATA_W-1:0] prod_o
);
    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned LEXT_W = PROD_W - DATA_W;
    localparam int unsigned WEXT_W = PROD_W - HALF_W;

    logic signed [PROD_W-1:0] ext_a;
    logic signed [PROD_W-1:0] ext_b;
    logic signed [PROD_W-1:0] prod_s;

    always_comb begin
        if (op_word_i) begin
            ext_a = {{WEXT_W{opa_i[HALF_W-1]}}, opa_i[HALF_W-1:0]};
            ext_b = {{WEXT_W{opb_i[HALF_W-1]}}, opb_i[HALF_W-1:0]};
        end else begin
            ext_a = {{LEXT_W{opa_i[DATA_W-1]}}, opa_i};
            ext_b = {{LEXT_W{opb_i[DATA_W-1]}}, opb_i};
        end
        prod_s = ext_a * ext_b;
        prod_o = prod_s;
    end

endmodule

// File: rtl/sat_mac_clip.sv
module sat_mac_clip #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16
) (
    input  logic [2*DATA_W-1:0] sum_i,
    input  logic                op_word_i,
    input  logic                sat_en_i,
    output logic [DATA_W-1:0]   hi_o,
    output logic [DATA_W-1:0]   lo_o
);
    localparam int unsigned ACC_W = 2 * DATA_W;
    localparam int unsigned TOP_W = ACC_W - DATA_W + 1;
    localparam logic [DATA_W-1:0] NEG_FILL  = {{HALF_W{1'b1}}, {(DATA_W-HALF_W){1'b0}}};
    localparam logic [DATA_W-1:0] POS_KEEP  = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] OVF_HI    = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] WORD_MIN  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] WORD_MAX  = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] raw_hi;
    logic [DATA_W-1:0] raw_lo;
    logic [TOP_W-1:0]  top_bits;
    logic              sum_neg;
    logic              word_out_of_range;

    assign raw_hi   = sum_i[ACC_W-1:DATA_W];
    assign raw_lo   = sum_i[DATA_W-1:0];
    assign top_bits = sum_i[ACC_W-1:DATA_W-1];
    assign sum_neg  = sum_i[ACC_W-1];
    assign word_out_of_range = !((&top_bits) || !(|top_bits));

    always_comb begin
        hi_o = raw_hi;
        lo_o = raw_lo;
        if (sat_en_i) begin
            if (!op_word_i) begin
                hi_o = sum_neg ? (raw_hi | NEG_FILL) : (raw_hi & POS_KEEP);
            end else if (word_out_of_range) begin
                hi_o = OVF_HI;
                lo_o = sum_neg ? WORD_MIN : WORD_MAX;
            end
        end
    end

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
    import sat_mac_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_hi_i,
    input  logic [DATA_W-1:0] load_lo_i,
    input  logic              start_i,
    input  logic              op_word_i,
    input  logic              sat_en_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] acc_hi_o,
    output logic [DATA_W-1:0] acc_lo_o,
    output logic              done_o
);
    localparam int unsigned SUM_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic              done;
    } acc_state_t;

    acc_state_t st_d, st_q;
    mac_cmd_e   cmd;

    logic [SUM_W-1:0]  prod;
    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] clip_hi;
    logic [DATA_W-1:0] clip_lo;

    sat_mac_mult #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mult (
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .op_word_i (op_word_i),
        .prod_o    (prod)
    );

    assign sum = {st_q.hi, st_q.lo} + prod;

    sat_mac_clip #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_clip (
        .sum_i     (sum),
        .op_word_i (op_word_i),
        .sat_en_i  (sat_en_i),
        .hi_o      (clip_hi),
        .lo_o      (clip_lo)
    );

    always_comb begin
        if (clr_i)        cmd = CMD_CLEAR;
        else if (load_i)  cmd = CMD_LOAD;
        else if (start_i) cmd = CMD_ACCUM;
        else              cmd = CMD_IDLE;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (cmd)
            CMD_CLEAR: begin
                st_d.hi = '0;
                st_d.lo = '0;
            end
            CMD_LOAD: begin
                st_d.hi = load_hi_i;
                st_d.lo = load_lo_i;
            end
            CMD_ACCUM: begin
                st_d.hi   = clip_hi;
                st_d.lo   = clip_lo;
                st_d.done = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_hi_o = st_q.hi;
    assign acc_lo_o = st_q.lo;
    assign done_o   = st_q.done;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_hi_o == '0 && acc_lo_o == '0 && !done_o)); // R8

    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (acc_hi_o == $past(load_hi_i) && acc_lo_o == $past(load_lo_i) && !done_o)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clr_i && !load_i) |=> done_o); // R7

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !clr_i && !load_i) |=> !done_o); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !clr_i && !load_i) |=> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R7

    AST_LONG_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clr_i && !load_i && sat_en_i && !op_word_i)
        |=> ((&acc_hi_o[DATA_W-1:DATA_W-HALF_W]) || !(|acc_hi_o[DATA_W-1:DATA_W-HALF_W-1]))); // R4

    AST_WORD_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clr_i && !load_i && sat_en_i && op_word_i)
        |=> ((acc_hi_o == '0 && !acc_lo_o[DATA_W-1])
          || (&acc_hi_o && acc_lo_o[DATA_W-1])
          || (acc_hi_o == DATA_W'(1) && (acc_lo_o == {1'b1, {(DATA_W-1){1'b0}}}
                                      || acc_lo_o == {1'b0, {(DATA_W-1){1'b1}}})))); // R5 R6

endmodule

// File: tb/sat_mac_unit_tb.sv
module sat_mac_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] load_hi_i = '0;
    logic [31:0] load_lo_i = '0;
    logic        start_i = 1'b0;
    logic        op_word_i = 1'b0;
    logic        sat_en_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] acc_hi_o;
    logic [31:0] acc_lo_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    longint m_acc = 0;
    bit     m_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_mac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(load_i),
        .load_hi_i(load_hi_i), .load_lo_i(load_lo_i), .start_i(start_i),
        .op_word_i(op_word_i), .sat_en_i(sat_en_i), .opa_i(opa_i), .opb_i(opb_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
    );

    function automatic longint model_accum(longint acc, bit word, bit sat, logic [31:0] a, logic [31:0] b);
        longint p;
        longint s;
        longint hi;
        longint lo;
        if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else      p = longint'($signed(a)) * longint'($signed(b));
        s = acc + p;
        if (!sat) return s;
        if (!word) begin
            hi = (s >>> 32) & 64'hFFFF_FFFF;
            lo = s & 64'hFFFF_FFFF;
            if (s < 0) hi = hi | 64'hFFFF_0000;
            else       hi = hi & 64'h0000_7FFF;
            return (hi << 32) | lo;
        end
        if (s < -64'sd2147483648) return 64'h0000_0001_8000_0000;
        if (s > 64'sd2147483647)  return 64'h0000_0001_7FFF_FFFF;
        return s;
    endfunction

    task automatic check_out(string tag);
        logic [63:0] exp_v;
        exp_v = m_acc;
        checks++;
        if (acc_hi_o !== exp_v[63:32] || acc_lo_o !== exp_v[31:0] || done_o !== m_done) begin
            errors++;
            $display("FAIL %s: got hi=%08h lo=%08h done=%0b expected hi=%08h lo=%08h done=%0b",
                     tag, acc_hi_o, acc_lo_o, done_o, exp_v[63:32], exp_v[31:0], m_done);
        end
    endtask

    task automatic step(input bit c, input bit l, input bit s, input bit w, input bit sat,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] lh, input logic [31:0] ll, input string tag);
        clr_i = c; load_i = l; start_i = s; op_word_i = w; sat_en_i = sat;
        opa_i = a; opb_i = b; load_hi_i = lh; load_lo_i = ll;
        @(posedge clk);
        if (c)      begin m_acc = 0; m_done = 0; end
        else if (l) begin m_acc = {lh, ll}; m_done = 0; end
        else if (s) begin m_acc = model_accum(m_acc, w, sat, a, b); m_done = 1; end
        else        m_done = 0;
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic mac(input bit w, input bit sat, input logic [31:0] a, input logic [31:0] b, input string tag);
        step(0, 0, 1, w, sat, a, b, 32'h0, 32'h0, tag);
    endtask

    task automatic load(input logic [31:0] lh, input logic [31:0] ll, input string tag);
        step(0, 1, 0, 0, 0, 32'h0, 32'h0, lh, ll, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0, tag);
    endtask

    task automatic expect_const(logic [31:0] eh, logic [31:0] el, string tag);
        checks++;
        if (acc_hi_o !== eh || acc_lo_o !== el) begin
            errors++;
            $display("FAIL %s: got hi=%08h lo=%08h expected hi=%08h lo=%08h", tag, acc_hi_o, acc_lo_o, eh, el);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check_out("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset");

        // R2: long form, no saturation, signs and wrap
        mac(0, 0, 32'd7, 32'd6, "R2 small");
        mac(0, 0, 32'hFFFF_FFFD, 32'd1000, "R2 neg*pos");
        mac(0, 0, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
        load(32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9 load near max");
        mac(0, 0, 32'd1, 32'd1, "R2 64-bit wrap");
        expect_const(32'h8000_0000, 32'h0000_0000, "R2 wrap value");

        // R3: word form ignores upper operand bits
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 clear");
        mac(1, 0, 32'hABCD_0003, 32'h1234_FFFE, "R3 upper bits ignored");
        expect_const(32'hFFFF_FFFF, 32'hFFFF_FFFA, "R3 value -6");
        mac(1, 0, 32'h0000_8000, 32'hFFFF_8000, "R3 min16*min16");

        // R4: long-form saturation
        load(32'h1234_5678, 32'h0000_0010, "R9 load");
        mac(0, 1, 32'd2, 32'd3, "R4 non-negative AND mask");
        expect_const(32'h0000_5678, 32'h0000_0016, "R4 masked hi");
        load(32'h8000_1234, 32'h0000_0000, "R9 load neg");
        mac(0, 1, 32'hFFFF_FFFF, 32'd1, "R4 negative OR fill");
        expect_const(32'hFFFF_1233, 32'hFFFF_FFFF, "R4 filled hi");

        // R5/R6: word-form saturation
        load(32'h0000_0000, 32'h7FFF_FFF0, "R9 load");
        mac(1, 1, 32'h0000_0100, 32'h0000_0100, "R6 positive overflow");
        expect_const(32'h0000_0001, 32'h7FFF_FFFF, "R6 code");
        mac(1, 1, 32'd1, 32'd1, "R6 re-saturate from code");
        load(32'hFFFF_FFFF, 32'h8000_0010, "R9 load");
        mac(1, 1, 32'h0000_0100, 32'hFFFF_FF00, "R5 negative overflow");
        expect_const(32'h0000_0001, 32'h8000_0000, "R5 code");
        load(32'h0000_0000, 32'h0000_0100, "R9 load");
        mac(1, 1, 32'h0000_7FFF, 32'h0000_8000, "R6 in range unchanged");
        load(32'h0000_0000, 32'h7FFF_FFF0, "R9 load");
        mac(1, 0, 32'h0000_0100, 32'h0000_0100, "R3 no sat wraps past 32 bits");

        // R7: hold, back-to-back starts
        idle("R7 idle hold");
        idle("R7 idle hold 2");
        mac(0, 0, 32'd5, 32'd5, "R7 start 1");
        mac(0, 0, 32'd5, 32'd5, "R7 start 2");
        idle("R7 done drops");

        // R8/R9: priorities
        step(1, 1, 1, 0, 0, 32'd9, 32'd9, 32'hDEAD_BEEF, 32'h1, "R8 clear beats load and start");
        step(0, 1, 1, 0, 0, 32'd9, 32'd9, 32'hCAFE_0000, 32'h2, "R9 load beats start");
        idle("R9 hold after load");

        // Mixed stream
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom;
            if (r % 23 == 0)      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 stream clear");
            else if (r % 17 == 0) load($urandom, $urandom, "R9 stream load");
            else if (r % 7 == 0)  idle("R7 stream idle");
            else                  mac(r[4], r[5], $urandom, $urandom, r[4] ? (r[5] ? "R5 R6 stream" : "R3 stream")
                                                                          : (r[5] ? "R4 stream" : "R2 stream"));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule